// File: doc/BRIEF.md
# Interrupt Router with Per-Source Fast Redirection

This block gathers a vector of interrupt inputs and steers each of them to one of two processor request lines: a normal, active-high request whose pending sources are ranked by index, or a single active-low fast request. Source 0 always feeds the fast line. Every other source goes to the normal line unless its redirect bit is set. A set bit moves the source onto the fast line and removes it from the normal request and from the normal ranking.

Each input passes through a two-flop synchronizer. A per-source mode bit selects level or rising-edge sensitivity. Edge capture keeps running whether or not a source is redirected, so moving a source between the two paths neither loses nor invents an event.

Software reaches the block through a small register bus that has no back-pressure. One access is accepted per cycle, and read data returns one cycle later with a valid strobe. Word addresses:
- 0: mode (read/write, 0 = level, 1 = rising edge)
- 1: redirect set (write 1 to set)
- 2: redirect clear (write 1 to clear)
- 3: redirect status (read)
- 4: fast vector (read)
- 5: normal vector (read)

Top module: `intc_ff_top`

## Requirements
- R1: After reset the fast output `fiq_n` is 1, `irq` is 0, and both the mode register and the redirect status read as 0.
- R2: A write to address 1 sets every redirect bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R3: A write to address 2 clears every redirect bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: An unredirected level source (index 1 or above) that goes high raises `irq` exactly three cycles later and leaves `fiq_n` at 1. For an edge source the delay is four cycles.
- R5: A redirected source never raises `irq` and is never returned by the normal vector.
- R6: A redirected level source drives `fiq_n` to 0 three cycles after it goes high and releases it three cycles after it goes low. A read of the fast vector does not release it.
- R7: A redirected edge source drives `fiq_n` to 0 four cycles after a rising edge, and `fiq_n` stays 0 after the input falls.
- R8: A read of address 4 returns a bitmap of the sources that are currently driving the fast line. The read clears every latched edge on the fast path, and `fiq_n` returns to 1 one cycle after the read if no level cause remains.
- R9: Source 0 drives the fast line whatever its redirect bit holds, and it never raises `irq`.
- R10: A read of address 5 returns, in bits [IW-1:0], the highest index among the pending sources that are not redirected, and a found flag in bit IW (IW = clog2(NSRC)). If that source is edge mode, its latch is cleared and `irq` falls one cycle later when nothing else is pending.
- R11: Read data and `bus_rvalid` appear on the cycle after the read is accepted. A write produces no `bus_rvalid`.
- R12: An edge captured while its source is redirected stays latched. Clearing the redirect moves it to `irq` one cycle later and releases `fiq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NSRC | Raw interrupt inputs |
| bus_valid | input | 1 | Access strobe, accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Normal request, active high, registered |
| fiq_n | output | 1 | Fast request, active low, registered |

## Verification
The latency from an input edge to an output is fixed:
- a level input reaches `irq` or `fiq_n` on the third rising clock edge after it changes, and an edge input on the fourth;
- the effect of a vector read or a redirect write shows on the next edge.

The bench drives inputs on falling edges. It samples once a cycle before each result is due, expecting the old value, and once on the cycle the result is due, expecting the new value. The sweep covers every source with every combination of mode and redirect setting, and every input pattern against a fixed redirect mask for the ranking.

// File: rtl/intc_ff_pkg.sv
package intc_ff_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FSET  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FCLR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FSTAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_FVEC  = 3'd4;
  localparam logic [ADDR_W-1:0] A_NVEC  = 3'd5;
endpackage

// File: rtl/intc_ff_sync.sv
module intc_ff_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= raw[b];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[b]  = s2;
    assign rise[b] = s2 & ~s3;
  end
endmodule

// File: rtl/intc_ff_regs.sv
module intc_ff_regs
  import intc_ff_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  input  logic [N-1:0]      fast_cause,
  input  logic              nvec_found,
  input  logic [IW-1:0]     nvec_idx,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      force_q,
  output logic [N-1:0]      bus_rdata,
  output logic              bus_rvalid,
  output logic              fast_ack,
  output logic              norm_ack
);
  logic wr, rd;
  logic [N-1:0] rd_mux, nvec_word;

  assign wr       = bus_valid & bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign fast_ack = rd & (bus_addr == A_FVEC);
  assign norm_ack = rd & (bus_addr == A_NVEC);

  always_comb begin
    nvec_word = '0;
    nvec_word[IW] = nvec_found;
    nvec_word[IW-1:0] = nvec_idx;
    case (bus_addr)
      A_MODE:  rd_mux = mode_q;
      A_FSTAT: rd_mux = force_q;
      A_FVEC:  rd_mux = fast_cause;
      A_NVEC:  rd_mux = nvec_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      force_q    <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
      if (wr && bus_addr == A_MODE) mode_q <= bus_wdata;
      if (wr && bus_addr == A_FSET) force_q <= force_q | bus_wdata;
      if (wr && bus_addr == A_FCLR) force_q <= force_q & ~bus_wdata;
    end
  end
endmodule

// File: rtl/intc_ff_route.sv
module intc_ff_route #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  lvl,
  input  logic [N-1:0]  rise,
  input  logic [N-1:0]  mode_q,
  input  logic [N-1:0]  force_q,
  input  logic          fast_ack,
  input  logic          norm_ack,
  output logic [N-1:0]  pend,
  output logic [N-1:0]  fast_mask,
  output logic [N-1:0]  fast_cause,
  output logic          nvec_found,
  output logic [IW-1:0] nvec_idx,
  output logic          fiq_n,
  output logic          irq
);
  logic [N-1:0] edge_q, norm_pend;

  always_comb begin
    fast_mask    = force_q;
    fast_mask[0] = 1'b1;
  end

  for (genvar b = 0; b < N; b++) begin : g_src
    logic clr;
    assign clr = (fast_ack & fast_mask[b]) |
                 (norm_ack & nvec_found & (nvec_idx == IW'(b)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  edge_q[b] <= 1'b0;
      else if (!mode_q[b])         edge_q[b] <= 1'b0;
      else if (rise[b])            edge_q[b] <= 1'b1;
      else if (clr)                edge_q[b] <= 1'b0;
    end
    assign pend[b] = mode_q[b] ? edge_q[b] : lvl[b];
  end

  assign fast_cause = pend & fast_mask;
  assign norm_pend  = pend & ~fast_mask;

  always_comb begin
    nvec_found = 1'b0;
    nvec_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (norm_pend[i]) begin
        nvec_found = 1'b1;
        nvec_idx   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_n <= 1'b1;
      irq   <= 1'b0;
    end else begin
      fiq_n <= ~(|fast_cause);
      irq   <= |norm_pend;
    end
  end
endmodule

// File: rtl/intc_ff_top.sv
module intc_ff_top
  import intc_ff_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              bus_rvalid,
  output logic              irq,
  output logic              fiq_n
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] lvl, rise, mode_q, force_q, pend_vec, fast_mask, fast_cause;
  logic            fast_ack, norm_ack, nvec_found;
  logic [IW-1:0]   nvec_idx;

  intc_ff_sync #(.N(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .lvl(lvl), .rise(rise)
  );

  intc_ff_regs #(.N(NSRC), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .fast_cause(fast_cause),
    .nvec_found(nvec_found), .nvec_idx(nvec_idx),
    .mode_q(mode_q), .force_q(force_q),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .fast_ack(fast_ack), .norm_ack(norm_ack)
  );

  intc_ff_route #(.N(NSRC), .IW(IW)) u_route (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise),
    .mode_q(mode_q), .force_q(force_q),
    .fast_ack(fast_ack), .norm_ack(norm_ack),
    .pend(pend_vec), .fast_mask(fast_mask), .fast_cause(fast_cause),
    .nvec_found(nvec_found), .nvec_idx(nvec_idx),
    .fiq_n(fiq_n), .irq(irq)
  );
endmodule

// File: rtl/intc_ff_chk.sv
module intc_ff_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_valid,
  input logic         bus_write,
  input logic [2:0]   bus_addr,
  input logic [N-1:0] bus_wdata,
  input logic         bus_rvalid,
  input logic [N-1:0] force_q,
  input logic [N-1:0] pend,
  input logic         irq,
  input logic         fiq_n
);
  logic [N-1:0] fmask;
  always_comb begin
    fmask    = force_q;
    fmask[0] = 1'b1;
  end

  // R2
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 3'd1)
      |=> ((force_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 3'd2)
      |=> ((force_q & $past(bus_wdata)) == '0));

  // R5
  a_r5_forced_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~fmask) == '0) |=> !irq);

  // R6
  a_r6_fast_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & fmask) != '0) |=> !fiq_n);

  // R8
  a_r8_fast_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & fmask) == '0) |=> fiq_n);

  // R11
  a_r11_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind intc_ff_top intc_ff_chk #(.N(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .force_q(force_q), .pend(pend_vec), .irq(irq), .fiq_n(fiq_n)
);

// File: tb/intc_ff_top_bench.sv
module intc_ff_top_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         bus_valid = 1'b0;
  logic         bus_write = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         bus_rvalid;
  logic         irq;
  logic         fiq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intc_ff_top #(.NSRC(N)) u_intc_ff_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq(irq), .fiq_n(fiq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    chk(bus_rvalid == 1'b0, "R11 write rvalid", int'(bus_rvalid), 0);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(bus_rvalid == 1'b1, "R11 read rvalid", int'(bus_rvalid), 1);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] d, st;
    logic [N-1:0] fm;
    int best;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(fiq_n == 1'b1, "R1 fiq_n", int'(fiq_n), 1);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    rd(3'd0, d); chk(d == '0, "R1 mode", int'(d), 0);
    rd(3'd3, d); chk(d == '0, "R1 status", int'(d), 0);

    // R2 R3 set/clear patterns
    st = '0;
    for (int k = 0; k < 16; k++) begin
      logic [N-1:0] s, c;
      s = N'((k * 73 + 5) & 8'hFF);
      c = N'((k * 151 + 9) & 8'hFF);
      wr(3'd1, s); st = st | s;
      rd(3'd3, d); chk(d == st, "R2 set", int'(d), int'(st));
      wr(3'd2, c); st = st & ~c;
      rd(3'd3, d); chk(d == st, "R3 clear", int'(d), int'(st));
    end
    wr(3'd2, '1);

    // Sweep: each source 1..N-1, mode level/edge, redirect off/on
    for (int i = 1; i < N; i++) begin
      for (int m = 0; m < 2; m++) begin
        for (int f = 0; f < 2; f++) begin
          int dl;
          dl = (m == 1) ? 4 : 3;
          wr(3'd0, m ? N'(1 << i) : '0);
          wr(3'd2, '1);
          if (f == 1) wr(3'd1, N'(1 << i));
          irq_in = N'(1 << i);
          idle(dl - 1);
          chk(fiq_n == 1'b1 && irq == 1'b0, (m ? "R4 R7 early" : "R4 R6 early"),
              int'({fiq_n, irq}), 2);
          idle(1);
          if (f == 1) begin
            chk(fiq_n == 1'b0, m ? "R7 fiq low" : "R6 fiq low", int'(fiq_n), 0);
            chk(irq == 1'b0, "R5 forced no irq", int'(irq), 0);
            rd(3'd5, d); chk(d[3] == 1'b0, "R5 nvec empty", int'(d), 0);
          end else begin
            chk(fiq_n == 1'b1 && irq == 1'b1, "R4 normal", int'({fiq_n, irq}), 1);
          end
          if (f == 1 && m == 0) begin
            rd(3'd4, d); chk(d == N'(1 << i), "R8 fvec bitmap", int'(d), 1 << i);
            idle(2);
            chk(fiq_n == 1'b0, "R6 level held after fvec", int'(fiq_n), 0);
          end
          irq_in = '0;
          idle(2);
          if (m == 0) begin
            chk(fiq_n == (f == 0) || irq == (f == 0), "R6 pre-release",
                int'({fiq_n, irq}), f ? 0 : 1);
            idle(1);
            chk(fiq_n == 1'b1 && irq == 1'b0, "R6 R4 release", int'({fiq_n, irq}), 2);
          end else begin
            idle(2);
            if (f == 1) begin
              chk(fiq_n == 1'b0, "R7 latched", int'(fiq_n), 0);
              rd(3'd4, d); chk(d == N'(1 << i), "R8 fvec bitmap edge", int'(d), 1 << i);
              chk(fiq_n == 1'b0, "R8 not yet", int'(fiq_n), 0);
              idle(1);
              chk(fiq_n == 1'b1, "R8 ack release", int'(fiq_n), 1);
            end else begin
              chk(irq == 1'b1, "R4 edge latched", int'(irq), 1);
              rd(3'd5, d); chk(d == N'(8 | i), "R10 nvec edge", int'(d), 8 | i);
              idle(1);
              chk(irq == 1'b0, "R10 ack release", int'(irq), 0);
            end
          end
        end
      end
    end

    // R9 source 0 always fast
    wr(3'd0, '0); wr(3'd2, '1);
    irq_in = 8'h01; idle(3);
    chk(fiq_n == 1'b0 && irq == 1'b0, "R9 src0 fast", int'({fiq_n, irq}), 0);
    irq_in = '0; idle(3);
    chk(fiq_n == 1'b1, "R9 src0 release", int'(fiq_n), 1);

    // R12 edge captured while redirected, then moved
    wr(3'd0, 8'h10); wr(3'd1, 8'h10);
    irq_in = 8'h10; idle(4); irq_in = '0; idle(2);
    chk(fiq_n == 1'b0 && irq == 1'b0, "R12 on fast", int'({fiq_n, irq}), 0);
    wr(3'd2, 8'h10);
    idle(1);
    chk(fiq_n == 1'b1 && irq == 1'b1, "R12 moved", int'({fiq_n, irq}), 3);
    rd(3'd5, d); chk(d == N'(8 | 4), "R12 R10 nvec", int'(d), 12);
    idle(1);

    // R10 R5 ranking sweep, levels, redirect mask 0x28
    wr(3'd0, '0); wr(3'd2, '1); wr(3'd1, 8'h28);
    fm = 8'h29;
    for (int p = 0; p < 256; p++) begin
      irq_in = N'(p);
      idle(3);
      best = -1;
      for (int b = 0; b < N; b++) if (p[b] && !fm[b]) best = b;
      chk(fiq_n == ((N'(p) & fm) == '0), "R6 R9 sweep fiq_n", int'(fiq_n),
          int'((N'(p) & fm) == '0));
      chk(irq == (best >= 0), "R5 sweep irq", int'(irq), int'(best >= 0));
      rd(3'd5, d);
      if (best >= 0) chk(d == N'(8 | best), "R10 rank", int'(d), 8 | best);
      else chk(d[3] == 1'b0, "R10 rank none", int'(d), 0);
    end
    irq_in = '0;
    idle(4);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule